// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers sixty-four interrupt request lines into one processor interrupt. Software configures each line through a small 32-bit register port. It sets the line's detection mode, which is either level or rising-edge-latched, and gives it a four-bit priority. It switches the line on or off through separate write-one-to-set and write-one-to-clear registers, each split into two 32-bit halves. A global generation bit gates the processor interrupt line.

The interrupt handler reads the vector register. That read returns the number of the best pending source, and it also marks the winner's priority level as in service. While a level is in service, only a strictly higher priority can raise the interrupt again. Writing the end-of-interrupt register drops the top in-service level, so nested interrupts unwind in order. For an edge source, the handler re-writes that source's setup register, which clears the captured edge. A soft-reset bit returns every controller register to zero.

Top module: `vec_intc_top`

## Requirements
- R1: After reset, irqOut is low, the enable halves and the global bit read 0, and the vector register (0x010) reads 64.
- R2: A write to 0x000 (sources 0–31) or 0x004 (sources 32–63) sets the enable of each source whose bit is 1 and leaves every other enable as it was. Reading 0x000 or 0x004 returns the enable state of that half.
- R3: A write to 0x008 (sources 0–31) or 0x00C (sources 32–63) clears the enable of each source whose bit is 1 and leaves the others as they were. A disabled source takes no part in arbitration. Reads of 0x008 and 0x00C return 0.
- R4: Each source n has a setup word at 0x100 + 8·n. Bits [3:0] hold the priority and bit 8 selects edge mode (1) or level mode (0). The setup word reads back as written. Any other address, including 0x104 + 8·n, reads as 0.
- R5: In level mode, a source is pending exactly while its request input is high, counted from the cycle after the input is sampled.
- R6: In edge mode, a rising edge on the input captures a pending flag that persists after the input falls. A write to that source's setup word clears the flag.
- R7: Among enabled pending sources, the highest priority wins, and a tie goes to the lowest source number. A read of 0x010 returns the winner, or 64 when no enabled source is pending.
- R8: irqOut stays low unless the global bit (bit 0 at 0x01C, readable) is set.
- R9: With the global bit set, irqOut is high when a winner exists and either nothing is in service or the winner's priority is strictly greater than the highest in-service priority. A vector read that returns a source marks that source's priority as in service.
- R10: A write of any value to 0x014 removes the highest in-service priority, so the level in service before it becomes current again.
- R11: A write with bit 0 set to 0x018 clears all enables, setup words, captured edges, in-service levels and the global bit. A write with bit 0 clear changes nothing.
- R12: Read data appears on regRdData in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Byte address of register access |
| regWrEn | input | 1 | Single-cycle write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Single-cycle read strobe |
| regRdData | output | 32 | Registered read data |
| reqIn | input | 64 | Raw interrupt request inputs |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The hardest condition to reach from the ports is nested in-service state. This is the case where irqOut must stay low even though an enabled source is pending, because that source's priority does not exceed a level that is already in service. Only the effects of a particular sequence of vector reads and end-of-interrupt writes make irqOut observable at that point. The stimulus builds the stack deliberately. It reads a priority-5 edge source, clears its capture, and then reads a priority-3 level source, which leaves two levels in service. It then raises a priority-4 source. The first end-of-interrupt write must then raise irqOut, while the second must leave it high. A tie between two priority-4 sources, followed by disabling the lower-numbered one, checks arbitration order against the same stack.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_CNT  = 64;
  localparam int HALF     = SRC_CNT / 2;
  localparam int IDX_W    = $clog2(SRC_CNT);
  localparam int EDGE_POS = 8;

  localparam int OFF_ENSET_LO = 'h000;
  localparam int OFF_ENSET_HI = 'h004;
  localparam int OFF_ENCLR_LO = 'h008;
  localparam int OFF_ENCLR_HI = 'h00C;
  localparam int OFF_VEC      = 'h010;
  localparam int OFF_EOI      = 'h014;
  localparam int OFF_RST      = 'h018;
  localparam int OFF_GEN      = 'h01C;
  localparam int CFG_BASE     = 'h100;
  localparam int CFG_STRIDE   = 8;
  localparam int CFG_END      = CFG_BASE + SRC_CNT * CFG_STRIDE;

  typedef enum logic [2:0] {
    RD_ZERO, RD_ENLO, RD_ENHI, RD_VEC, RD_GEN, RD_CFG
  } rdSel_t;

  typedef struct packed {
    logic             enSetLo;
    logic             enSetHi;
    logic             enClrLo;
    logic             enClrHi;
    logic             eoi;
    logic             softRst;
    logic             genWr;
    logic             cfgWr;
    logic             vecRd;
    logic             rdEn;
    rdSel_t           rdSel;
    logic [IDX_W-1:0] idx;
  } ctrlCmd_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrBit0,
  input  logic              regRdEn,
  output ctrlCmd_t          cmd
);
  logic              cfgHit;
  logic [ADDR_W-1:0] cfgOff;

  always_comb begin
    cfgOff = regAddr - ADDR_W'(CFG_BASE);
    cfgHit = (regAddr >= ADDR_W'(CFG_BASE)) && (regAddr < ADDR_W'(CFG_END))
             && (regAddr[2:0] == 3'b000);
  end

  always_comb begin
    cmd       = '0;
    cmd.rdSel = RD_ZERO;
    cmd.idx   = IDX_W'(cfgOff >> 3);
    if (regWrEn) begin
      case (regAddr)
        ADDR_W'(OFF_ENSET_LO): cmd.enSetLo = 1'b1;
        ADDR_W'(OFF_ENSET_HI): cmd.enSetHi = 1'b1;
        ADDR_W'(OFF_ENCLR_LO): cmd.enClrLo = 1'b1;
        ADDR_W'(OFF_ENCLR_HI): cmd.enClrHi = 1'b1;
        ADDR_W'(OFF_EOI):      cmd.eoi     = 1'b1;
        ADDR_W'(OFF_RST):      cmd.softRst = wrBit0;
        ADDR_W'(OFF_GEN):      cmd.genWr   = 1'b1;
        default:               cmd.cfgWr   = cfgHit;
      endcase
    end
    if (regRdEn) begin
      cmd.rdEn = 1'b1;
      case (regAddr)
        ADDR_W'(OFF_ENSET_LO): cmd.rdSel = RD_ENLO;
        ADDR_W'(OFF_ENSET_HI): cmd.rdSel = RD_ENHI;
        ADDR_W'(OFF_VEC): begin
          cmd.rdSel = RD_VEC;
          cmd.vecRd = 1'b1;
        end
        ADDR_W'(OFF_GEN):      cmd.rdSel = RD_GEN;
        default:               cmd.rdSel = cfgHit ? RD_CFG : RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlCmd_t           cmd,
  input  logic [31:0]        wrData,
  input  logic [SRC_CNT-1:0] reqIn,
  output logic [31:0]        rdData,
  output logic               irqOut
);
  localparam int PRIO_LVLS = 1 << PRIO_W;

  logic [SRC_CNT-1:0]   enMask, enNext;
  logic [SRC_CNT-1:0]   edgeLatch, reqQ, cfgEdge;
  logic [SRC_CNT-1:0]   pendRaw, pendMasked, cfgHitVec, riseVec;
  logic [PRIO_W-1:0]    cfgPrio [SRC_CNT];
  logic                 genEn;
  logic [PRIO_LVLS-1:0] inSvc, svcNext, svcTop;
  logic                 svcAny;
  logic [PRIO_W-1:0]    curPrio;
  logic                 winValid;
  logic [IDX_W-1:0]     winIdx;
  logic [PRIO_W-1:0]    winPrio;
  logic [31:0]          vecVal, cfgWord, rdMux;

  // per-source pending selection and setup-write decode
  for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
    assign pendRaw[s]   = cfgEdge[s] ? edgeLatch[s] : reqQ[s];
    assign cfgHitVec[s] = cmd.cfgWr && (cmd.idx == IDX_W'(s));
  end

  assign pendMasked = pendRaw & enMask;
  assign riseVec    = reqIn & ~reqQ & cfgEdge;

  // arbitration: strictly greater replaces, so ties keep the lower index
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    for (int i = 0; i < SRC_CNT; i++) begin
      if (pendMasked[i] && (!winValid || cfgPrio[i] > winPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = cfgPrio[i];
      end
    end
    vecVal = winValid ? 32'(winIdx) : 32'(SRC_CNT);
  end

  // highest in-service level
  always_comb begin
    curPrio = '0;
    for (int l = 0; l < PRIO_LVLS; l++) begin
      if (inSvc[l]) curPrio = PRIO_W'(l);
    end
    svcAny          = |inSvc;
    svcTop          = '0;
    svcTop[curPrio] = svcAny;
  end

  always_comb begin
    svcNext = inSvc;
    if (cmd.vecRd && winValid) svcNext[winPrio] = 1'b1;
    if (cmd.eoi)               svcNext = inSvc & ~svcTop;
  end

  always_comb begin
    enNext = enMask;
    if (cmd.enSetLo) enNext[HALF-1:0]       = enMask[HALF-1:0] | wrData;
    if (cmd.enSetHi) enNext[SRC_CNT-1:HALF] = enMask[SRC_CNT-1:HALF] | wrData;
    if (cmd.enClrLo) enNext[HALF-1:0]       = enMask[HALF-1:0] & ~wrData;
    if (cmd.enClrHi) enNext[SRC_CNT-1:HALF] = enMask[SRC_CNT-1:HALF] & ~wrData;
  end

  always_comb begin
    cfgWord                 = '0;
    cfgWord[PRIO_W-1:0]     = cfgPrio[cmd.idx];
    cfgWord[EDGE_POS]       = cfgEdge[cmd.idx];
    case (cmd.rdSel)
      RD_ENLO: rdMux = enMask[HALF-1:0];
      RD_ENHI: rdMux = enMask[SRC_CNT-1:HALF];
      RD_VEC:  rdMux = vecVal;
      RD_GEN:  rdMux = {31'd0, genEn};
      RD_CFG:  rdMux = cfgWord;
      default: rdMux = '0;
    endcase
  end

  assign irqOut = genEn && winValid && (!svcAny || (winPrio > curPrio));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask    <= '0;
      edgeLatch <= '0;
      reqQ      <= '0;
      cfgEdge   <= '0;
      genEn     <= 1'b0;
      inSvc     <= '0;
      rdData    <= '0;
      for (int i = 0; i < SRC_CNT; i++) cfgPrio[i] <= '0;
    end else begin
      reqQ <= reqIn;
      if (cmd.rdEn) rdData <= rdMux;
      if (cmd.softRst) begin
        enMask    <= '0;
        edgeLatch <= '0;
        cfgEdge   <= '0;
        genEn     <= 1'b0;
        inSvc     <= '0;
        for (int i = 0; i < SRC_CNT; i++) cfgPrio[i] <= '0;
      end else begin
        enMask    <= enNext;
        edgeLatch <= ((edgeLatch & ~cfgHitVec) | riseVec) & cfgEdge;
        inSvc     <= svcNext;
        if (cmd.genWr) genEn <= wrData[0];
        if (cmd.cfgWr) begin
          cfgPrio[cmd.idx] <= wrData[PRIO_W-1:0];
          cfgEdge[cmd.idx] <= wrData[EDGE_POS];
        end
      end
    end
  end

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.softRst |=> (enMask == '0 && !genEn && inSvc == '0 && edgeLatch == '0)); // R11
  AST_ENSET_LO_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.enSetLo && !cmd.softRst) |=> ((enMask[HALF-1:0] & $past(wrData)) == $past(wrData))); // R2
  AST_ENCLR_HI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.enClrHi && !cmd.softRst) |=> ((enMask[SRC_CNT-1:HALF] & $past(wrData)) == '0)); // R3
  AST_EOI_POPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.eoi && inSvc != '0) |=> ($countones(inSvc) + 1 == $countones($past(inSvc)))); // R10
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.vecRd |=> (rdData <= 32'(SRC_CNT))); // R7
endmodule

// File: rtl/vec_intc_top.sv
module vec_intc_top
  import intc_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  input  logic               regRdEn,
  output logic [31:0]        regRdData,
  input  logic [SRC_CNT-1:0] reqIn,
  output logic               irqOut
);
  ctrlCmd_t cmd;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .wrBit0  (regWrData[0]),
    .regRdEn (regRdEn),
    .cmd     (cmd)
  );

  intc_datapath #(.PRIO_W(PRIO_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wrData (regWrData),
    .reqIn  (reqIn),
    .rdData (regRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/vec_intc_top_test.sv
`timescale 1ns/1ps
module vec_intc_top_test;
  localparam logic [11:0] A_ENLO = 12'h000, A_ENHI = 12'h004, A_DISLO = 12'h008,
                          A_DISHI = 12'h00C, A_VEC = 12'h010, A_EOI = 12'h014,
                          A_RST = 12'h018, A_GEN = 12'h01C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [63:0] reqIn = '0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #5 clk = ~clk;

  vec_intc_top uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .reqIn(reqIn), .irqOut(irqOut)
  );

  function automatic logic [11:0] cfgAddr(int n);
    return 12'(12'h100 + n * 8);
  endfunction

  task automatic checkVal(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected read data in the cycle after each read strobe (R12)
  always @(posedge clk) rdSeen <= regRdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        checkVal("scoreboard underflow", regRdData, 32'hx);
      end else begin
        checkVal(tagQ.pop_front(), regRdData, expQ.pop_front());
      end
    end
  end

  task automatic wrReg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setReq(int n, logic v);
    @(negedge clk);
    reqIn[n] = v;
  endtask

  task automatic checkIrq(logic exp, string tag);
    @(negedge clk);
    checkVal(tag, 32'(irqOut), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1 irq after reset");
    rdReg(A_ENLO, 32'h0, "R1 enable low after reset");
    rdReg(A_VEC, 32'd64, "R1 vector after reset");
    rdReg(A_GEN, 32'h0, "R1 global bit after reset");

    // R4 setup words
    wrReg(cfgAddr(5), 32'h003);
    wrReg(cfgAddr(40), 32'h105);
    rdReg(cfgAddr(5), 32'h003, "R4 setup readback level");
    rdReg(cfgAddr(40), 32'h105, "R4 setup readback edge");
    rdReg(12'(cfgAddr(5) + 4), 32'h0, "R4 odd word reads zero");
    rdReg(12'h3F0, 32'h0, "R4 unmapped reads zero");

    // R2 / R3 enable halves
    wrReg(A_ENLO, 32'h20);
    wrReg(A_ENHI, 32'h100);
    rdReg(A_ENLO, 32'h20, "R2 enable low set");
    wrReg(A_ENLO, 32'h1);
    rdReg(A_ENLO, 32'h21, "R2 set keeps other bits");
    wrReg(A_ENHI, 32'h1);
    rdReg(A_ENHI, 32'h101, "R2 enable high set");
    wrReg(A_DISLO, 32'h1);
    rdReg(A_ENLO, 32'h20, "R3 disable clears only bit 0");
    rdReg(A_DISLO, 32'h0, "R3 disable register reads zero");

    // R8 global gate, R5 level following
    setReq(5, 1'b1);
    checkIrq(1'b0, "R8 no irq while global bit clear");
    wrReg(A_GEN, 32'h1);
    checkIrq(1'b1, "R8 irq once global bit set");
    rdReg(A_GEN, 32'h1, "R8 global bit readback");
    setReq(5, 1'b0);
    checkIrq(1'b0, "R5 level source drops with input");
    rdReg(A_VEC, 32'd64, "R5 vector empty after input low");
    setReq(5, 1'b1);

    // R6 edge capture, R7 priority, R9 in-service masking
    setReq(40, 1'b1);
    setReq(40, 1'b0);
    rdReg(A_VEC, 32'd40, "R7 higher priority edge source wins");
    checkIrq(1'b0, "R9 equal priority to in-service is masked");
    wrReg(cfgAddr(40), 32'h105);
    rdReg(A_VEC, 32'd5, "R6 setup write clears captured edge");

    // R10 end-of-interrupt restores previous level
    wrReg(cfgAddr(7), 32'h004);
    wrReg(A_ENLO, 32'h80);
    setReq(7, 1'b1);
    checkIrq(1'b0, "R9 priority 4 below in-service 5");
    wrReg(A_EOI, 32'hDEAD);
    checkIrq(1'b1, "R10 first eoi exposes level 3");
    wrReg(A_EOI, 32'h0);
    checkIrq(1'b1, "R10 second eoi empties service");

    // R7 tie to lowest number, R3 disabled source leaves arbitration
    wrReg(cfgAddr(9), 32'h004);
    wrReg(A_ENLO, 32'h200);
    setReq(9, 1'b1);
    rdReg(A_VEC, 32'd7, "R7 tie goes to lower number");
    checkIrq(1'b0, "R9 tie partner masked by in-service");
    wrReg(A_DISLO, 32'h80);
    rdReg(A_ENLO, 32'h220, "R3 enable low after disable");
    rdReg(A_VEC, 32'd9, "R3 disabled source skipped");
    wrReg(A_EOI, 32'h0);
    checkIrq(1'b1, "R10 irq back after eoi");

    // R11 soft reset
    wrReg(A_RST, 32'h0);
    rdReg(A_ENLO, 32'h220, "R11 reset bit clear has no effect");
    wrReg(A_RST, 32'h1);
    checkIrq(1'b0, "R11 irq after soft reset");
    rdReg(A_ENLO, 32'h0, "R11 enable low cleared");
    rdReg(A_ENHI, 32'h0, "R11 enable high cleared");
    rdReg(A_GEN, 32'h0, "R11 global bit cleared");
    rdReg(cfgAddr(9), 32'h0, "R11 setup word cleared");
    rdReg(A_VEC, 32'd64, "R11 vector empty after soft reset");

    // R12 read data holds between reads
    repeat (3) @(negedge clk);
    checkVal("R12 read data held", regRdData, 32'd64);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule